// File: doc/BRIEF.md
# Serial Master Result Transmitter

This block returns a 16-bit acquisition result to a host over a shared serial bus, acting as the bus master. The host asks for a measurement by holding an active-low request line low for a minimum time. The block then starts an external acquisition through a start/done handshake. When the result arrives, the block pulls an active-low ready line low, waits a lead interval, and clocks out the high byte and then the low byte. It drives the serial clock itself at a programmed rate. Between the two bytes the ready line goes high for a programmed gap, so each byte is framed by a low pulse on the ready line.

All timing is counted in ticks of 1/1.2 µs from a free-running prescaler. Each clock phase, high and low, lasts 15 + 4·rate_code ticks, so a full period is (30 + 8·rate_code)/1.2 µs. The gap between the bytes lasts 10 + 4·gap_code ticks. Both codes and the clock polarity are latched when the acquisition completes. Clock, data and ready have separate output enables, and all three enables are low whenever the block is not transmitting, so several units can share the same lines.

If the request is still held low when the acquisition finishes, the block enters a setup state instead of transmitting. It stays there until the request is released.

Top module: `spi_result_master`

## Requirements
- R1: After reset, sck_oe_o, sdo_oe_o, rdy_oe_o, acq_start_o and setup_o are all low.
- R2: acq_start_o pulses high for exactly one cycle once req_ni has been seen low for REQ_MIN_TICKS consecutive ticks while idle. A low pulse shorter than REQ_MIN_TICKS−1 ticks starts nothing.
- R3: If req_ni is still low when acq_done_i arrives, setup_o goes high, all three output enables stay low and no bits are sent. setup_o clears once req_ni returns high.
- R4: On acq_done_i with req_ni high, the enables rise with rdy_no low. The first active clock edge of each byte follows the ready-low edge by at least LEAD_TICKS ticks and at most LEAD_TICKS+1 ticks.
- R5: Each clock phase, active and idle, lasts exactly 15 + 4·rate_code_i ticks. rate_code_i is latched at completion.
- R6: The 16-bit result goes out high byte first, most significant bit first, followed by the low byte.
- R7: Between the bytes, rdy_no is driven high for exactly 10 + 4·gap_code_i ticks while sck_o rests at its idle level. rdy_no then returns low before the low byte.
- R8: With mode_idle_high_i = 0 the clock idles low, sdo_o changes on rising edges and is valid on falling edges. With mode_idle_high_i = 1 the clock idles high and both edges swap roles.
- R9: After the last bit, the enables drop one idle phase (15 + 4·rate_code_i ticks) after the final sampling edge, and rdy_oe_o falls together with the clock and data enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_ni | input | 1 | Active-low acquisition request from host (asynchronous) |
| mode_idle_high_i | input | 1 | Clock idle level: 0 idles low, 1 idles high |
| rate_code_i | input | 8 | Serial clock rate code |
| gap_code_i | input | 8 | Inter-byte gap code |
| acq_start_o | output | 1 | One-cycle pulse starting the external acquisition |
| acq_done_i | input | 1 | External acquisition finished; result valid this cycle |
| acq_result_i | input | 16 | Acquisition result |
| setup_o | output | 1 | Block is in the setup state |
| sck_o | output | 1 | Serial clock value |
| sck_oe_o | output | 1 | Serial clock output enable |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output enable |
| rdy_no | output | 1 | Active-low data-ready value |
| rdy_oe_o | output | 1 | Data-ready output enable |

## Verification
The hardest situation to reach from the ports is the setup state. It needs the host's request to stay low past the end of an acquisition that the request itself started. The bench models the acquisition with a fixed latency. It holds req_ni low through acq_start_o and the done pulse, then checks that the block stays silent and leaves the setup state on release. The unaligned lead interval is checked against a window, because acq_done_i can land anywhere relative to the tick. Every later phase is tick-aligned and is checked to the exact cycle.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACQ   = 3'd1,
    ST_SETUP = 3'd2,
    ST_LEAD  = 3'd3,
    ST_ACT   = 3'd4,
    ST_IDL   = 3'd5,
    ST_GAP   = 3'd6
  } tx_state_e;
endpackage

// File: rtl/spi_rm_prescaler.sv
module spi_rm_prescaler #(
  parameter int TICK_DIV = 167
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/spi_rm_req_detect.sv
module spi_rm_req_detect #(
  parameter int REQ_MIN_TICKS = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic tick_i,
  input  logic arm_i,
  output logic req_low_o,
  output logic fire_o
);
  localparam int RW = $clog2(REQ_MIN_TICKS + 1);
  localparam logic [RW-1:0] FIRE_AT = RW'(REQ_MIN_TICKS - 1);
  localparam logic [RW-1:0] SAT     = RW'(REQ_MIN_TICKS);

  logic s1_q, s2_q;
  logic [RW-1:0] cnt_q;

  // two-flop synchronizer, idles released (high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= req_ni;
      s2_q <= s1_q;
    end
  end

  assign req_low_o = ~s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!arm_i || !req_low_o) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != SAT) begin
      cnt_q <= cnt_q + RW'(1);
    end
  end

  assign fire_o = arm_i && req_low_o && tick_i && (cnt_q == FIRE_AT);
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine import spi_rm_pkg::*; #(
  parameter int BYTE_W     = 8,
  parameter int NUM_BYTES  = 2,
  parameter int CODE_W     = 8,
  parameter int LEAD_TICKS = 15,
  parameter int HALF_BASE  = 15,
  parameter int HALF_STEP  = 4,
  parameter int GAP_BASE   = 10,
  parameter int GAP_STEP   = 4,
  localparam int DATA_W    = BYTE_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fire_i,
  input  logic              req_low_i,
  input  logic              acq_done_i,
  input  logic [DATA_W-1:0] acq_result_i,
  input  logic              mode_idle_high_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic [CODE_W-1:0] gap_code_i,
  output logic              arm_o,
  output logic              acq_start_o,
  output logic              setup_o,
  output logic              active_o,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              rdy_no
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int MAX_HALF = HALF_BASE + HALF_STEP * CODE_MAX;
  localparam int MAX_GAP  = GAP_BASE + GAP_STEP * CODE_MAX;
  localparam int MAX_A    = (MAX_HALF > MAX_GAP) ? MAX_HALF : MAX_GAP;
  localparam int MAX_CNT  = (MAX_A > LEAD_TICKS) ? MAX_A : LEAD_TICKS;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam int BIT_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int BYI_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [BYI_W-1:0] BYTE_LAST = BYI_W'(NUM_BYTES - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, half_q, gap_q;
  logic [BIT_W-1:0] bit_q;
  logic [BYI_W-1:0] byte_q;
  logic             idle_hi_q, sdo_q, start_q;
  logic             expire, load, bit_start, msb;

  assign expire    = tick_i && (cnt_q == '0);
  assign load      = (state_q == ST_ACQ) && acq_done_i && !req_low_i;
  assign bit_start = expire && ((state_q == ST_LEAD) ||
                     ((state_q == ST_IDL) && (bit_q != BIT_LAST)));

  spi_rm_shifter #(.W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (acq_result_i),
    .shift_i(bit_start),
    .msb_o  (msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      half_q    <= '0;
      gap_q     <= '0;
      bit_q     <= '0;
      byte_q    <= '0;
      idle_hi_q <= 1'b0;
      sdo_q     <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (bit_start) sdo_q <= msb;
      unique case (state_q)
        ST_IDLE: if (fire_i) begin
          state_q <= ST_ACQ;
          start_q <= 1'b1;
        end
        ST_ACQ: if (acq_done_i) begin
          if (req_low_i) begin
            state_q <= ST_SETUP;
          end else begin
            state_q   <= ST_LEAD;
            cnt_q     <= CNT_W'(LEAD_TICKS);   // unaligned entry: one spare tick
            idle_hi_q <= mode_idle_high_i;
            half_q    <= CNT_W'(HALF_BASE) + CNT_W'(HALF_STEP) * CNT_W'(rate_code_i);
            gap_q     <= CNT_W'(GAP_BASE) + CNT_W'(GAP_STEP) * CNT_W'(gap_code_i);
            sdo_q     <= 1'b0;
            byte_q    <= '0;
          end
        end
        ST_SETUP: if (!req_low_i) state_q <= ST_IDLE;
        ST_LEAD: if (tick_i) begin
          if (expire) begin
            state_q <= ST_ACT;
            cnt_q   <= half_q - CNT_W'(1);
            bit_q   <= '0;
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_ACT: if (tick_i) begin
          if (expire) begin
            state_q <= ST_IDL;
            cnt_q   <= half_q - CNT_W'(1);
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_IDL: if (tick_i) begin
          if (expire) begin
            if (bit_q == BIT_LAST) begin
              if (byte_q == BYTE_LAST) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_GAP;
                cnt_q   <= gap_q - CNT_W'(1);
                byte_q  <= byte_q + BYI_W'(1);
              end
            end else begin
              state_q <= ST_ACT;
              cnt_q   <= half_q - CNT_W'(1);
              bit_q   <= bit_q + BIT_W'(1);
            end
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_GAP: if (tick_i) begin
          if (expire) begin
            state_q <= ST_LEAD;
            cnt_q   <= CNT_W'(LEAD_TICKS - 1);
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arm_o       = (state_q == ST_IDLE);
  assign acq_start_o = start_q;
  assign setup_o     = (state_q == ST_SETUP);
  assign active_o    = (state_q == ST_LEAD) || (state_q == ST_ACT) ||
                       (state_q == ST_IDL)  || (state_q == ST_GAP);
  assign sck_o       = (state_q == ST_ACT) ? ~idle_hi_q : idle_hi_q;
  assign sdo_o       = sdo_q;
  assign rdy_no      = ~((state_q == ST_LEAD) || (state_q == ST_ACT) || (state_q == ST_IDL));
endmodule

// File: rtl/spi_result_master.sv
module spi_result_master #(
  parameter int TICK_DIV      = 167,
  parameter int REQ_MIN_TICKS = 36,
  parameter int LEAD_TICKS    = 15,
  parameter int CODE_W        = 8,
  parameter int BYTE_W        = 8,
  parameter int NUM_BYTES     = 2,
  localparam int DATA_W       = BYTE_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_ni,
  input  logic              mode_idle_high_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic [CODE_W-1:0] gap_code_i,
  output logic              acq_start_o,
  input  logic              acq_done_i,
  input  logic [DATA_W-1:0] acq_result_i,
  output logic              setup_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              rdy_no,
  output logic              rdy_oe_o
);
  logic tick, arm, req_low, fire, active;

  spi_rm_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  spi_rm_req_detect #(.REQ_MIN_TICKS(REQ_MIN_TICKS)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_ni   (req_ni),
    .tick_i   (tick),
    .arm_i    (arm),
    .req_low_o(req_low),
    .fire_o   (fire)
  );

  spi_rm_engine #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .CODE_W    (CODE_W),
    .LEAD_TICKS(LEAD_TICKS)
  ) u_eng (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .tick_i          (tick),
    .fire_i          (fire),
    .req_low_i       (req_low),
    .acq_done_i      (acq_done_i),
    .acq_result_i    (acq_result_i),
    .mode_idle_high_i(mode_idle_high_i),
    .rate_code_i     (rate_code_i),
    .gap_code_i      (gap_code_i),
    .arm_o           (arm),
    .acq_start_o     (acq_start_o),
    .setup_o         (setup_o),
    .active_o        (active),
    .sck_o           (sck_o),
    .sdo_o           (sdo_o),
    .rdy_no          (rdy_no)
  );

  assign sck_oe_o = active;
  assign sdo_oe_o = active;
  assign rdy_oe_o = active;
endmodule

// File: rtl/spi_rm_checker.sv
module spi_rm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic acq_start_o,
  input logic setup_o,
  input logic sck_o,
  input logic sck_oe_o,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic rdy_no,
  input logic rdy_oe_o
);
  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_o |=> !acq_start_o);

  assert_setup_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_o |-> (!sck_oe_o && !sdo_oe_o && !rdy_oe_o));

  assert_edge_needs_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_o && $past(sck_oe_o) && !$stable(sck_o)) |-> !rdy_no);

  assert_gap_clock_rest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_oe_o && rdy_no) |-> $stable(sck_o));

  assert_data_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && $stable(sck_o)) |-> $stable(sdo_o));

  assert_release_after_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_oe_o) |-> !$past(rdy_no));
endmodule

bind spi_result_master spi_rm_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acq_start_o(acq_start_o),
  .setup_o    (setup_o),
  .sck_o      (sck_o),
  .sck_oe_o   (sck_oe_o),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .rdy_no     (rdy_no),
  .rdy_oe_o   (rdy_oe_o)
);

// File: tb/spi_result_master_bench.sv
`timescale 1ns/1ps
module spi_result_master_bench;
  localparam int D     = 4;
  localparam int REQ_T = 36;
  localparam int LEAD  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic mode = 1'b0;
  logic [7:0] rate = 8'd0, gap = 8'd0;
  logic acq_start, acq_done = 1'b0;
  logic [15:0] acq_res = '0;
  logic setup, sck, sck_oe, sdo, sdo_oe, rdy_n, rdy_oe;

  always #2.5 clk = ~clk;

  spi_result_master #(.TICK_DIV(D), .REQ_MIN_TICKS(REQ_T), .LEAD_TICKS(LEAD)) u_spi_result_master (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .mode_idle_high_i(mode),
    .rate_code_i(rate), .gap_code_i(gap), .acq_start_o(acq_start),
    .acq_done_i(acq_done), .acq_result_i(acq_res), .setup_o(setup),
    .sck_o(sck), .sck_oe_o(sck_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .rdy_no(rdy_n), .rdy_oe_o(rdy_oe)
  );

  int checks = 0, errors = 0;
  int cyc = 0, start_cnt = 0, done_cnt = 0;
  logic [15:0] exp_q[$];
  logic [15:0] next_word = '0;
  int cur_half = 0, cur_gap = 0;
  logic cur_mode = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // acquisition model: fixed latency after start
  initial begin
    forever begin
      @(negedge clk);
      if (acq_start) begin
        start_cnt++;
        repeat (20) @(negedge clk);
        acq_res  = next_word;
        acq_done = 1'b1;
        @(negedge clk);
        acq_done = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    logic p_oe, p_sck, p_rdy;
    logic [15:0] word, expw;
    int nbits, t_rdy, t_act, t_inact, t_gap;
    p_oe = 0; p_sck = 0; p_rdy = 1; word = '0; nbits = 0;
    t_rdy = 0; t_act = 0; t_inact = 0; t_gap = 0;
    forever begin
      @(negedge clk);
      if (sck_oe && !p_oe) begin
        t_rdy = cyc; nbits = 0; word = '0;
        check(rdy_n == 1'b0, "R4 ready low at start", rdy_n, 0);
      end
      if (sck_oe && p_oe) begin
        if (!p_rdy && rdy_n) begin
          t_gap = cyc;
          check(sck == cur_mode, "R7 clock idle in gap", sck, cur_mode);
        end
        if (p_rdy && !rdy_n) begin
          check(cyc - t_gap == cur_gap * D, "R7 gap length", cyc - t_gap, cur_gap * D);
          t_rdy = cyc;
        end
        if (p_sck == cur_mode && sck != cur_mode) begin
          if (nbits == 0 || nbits == 8)
            check(cyc - t_rdy >= LEAD * D && cyc - t_rdy <= (LEAD + 1) * D,
                  "R4 lead window", cyc - t_rdy, LEAD * D);
          t_act = cyc;
        end
        if (p_sck != cur_mode && sck == cur_mode) begin
          check(cyc - t_act == cur_half * D, "R5 active phase", cyc - t_act, cur_half * D);
          word = {word[14:0], sdo};   // R8 sample on inactive edge
          nbits++;
          t_inact = cyc;
        end
      end
      if (!sck_oe && p_oe) begin
        check(cyc - t_inact == cur_half * D, "R9 final idle phase", cyc - t_inact, cur_half * D);
        check(!rdy_oe && !sdo_oe, "R9 all enables drop", {rdy_oe, sdo_oe}, 0);
        check(nbits == 16, "R6 bit count", nbits, 16);
        if (exp_q.size() > 0) begin
          expw = exp_q.pop_front();
          check(word == expw, "R6 R8 word order", word, expw);
        end else check(0, "R6 unexpected word", word, 0);
        done_cnt++;
      end
      p_oe = sck_oe; p_sck = sck; p_rdy = rdy_n;
    end
  end

  task automatic pulse_req(input int cycles);
    @(negedge clk);
    req_n = 1'b0;
    repeat (cycles) @(negedge clk);
    req_n = 1'b1;
  endtask

  task automatic run_txn(input logic [15:0] w, input int rc, input int gc, input logic m);
    int d0;
    @(negedge clk);
    rate = 8'(rc); gap = 8'(gc); mode = m; next_word = w;
    cur_half = 15 + 4 * rc; cur_gap = 10 + 4 * gc; cur_mode = m;
    exp_q.push_back(w);
    d0 = done_cnt;
    pulse_req((REQ_T + 2) * D);
    wait (done_cnt != d0);
    repeat (20) @(negedge clk);
    check(sck == m, "R8 idle level after txn", sck, m);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, d0;
    repeat (3) @(negedge clk);
    check(!sck_oe && !sdo_oe && !rdy_oe, "R1 enables in reset", {sck_oe, sdo_oe, rdy_oe}, 0);
    check(!acq_start && !setup, "R1 start/setup in reset", {acq_start, setup}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!sck_oe && !acq_start && !setup, "R1 idle after reset", {sck_oe, acq_start, setup}, 0);

    // short request ignored
    s0 = start_cnt;
    pulse_req((REQ_T - 2) * D);
    repeat (60) @(negedge clk);
    check(start_cnt == s0, "R2 short request ignored", start_cnt, s0);
    check(!sck_oe, "R2 no transfer on short request", sck_oe, 0);

    s0 = start_cnt;
    run_txn(16'hA5C3, 0, 2, 1'b0);
    check(start_cnt == s0 + 1, "R2 single start per request", start_cnt, s0 + 1);
    run_txn(16'h3C5A, 3, 0, 1'b1);
    run_txn(16'hFF00, 1, 5, 1'b0);
    run_txn(16'h0001, 0, 1, 1'b1);

    // setup state: request held through completion
    @(negedge clk);
    next_word = 16'h1234; mode = 1'b0;
    s0 = start_cnt; d0 = done_cnt;
    req_n = 1'b0;
    wait (start_cnt != s0);
    wait (acq_done);
    repeat (5) @(negedge clk);
    check(setup == 1'b1, "R3 setup entered", setup, 1);
    check(!sck_oe && !sdo_oe && !rdy_oe, "R3 outputs stay off", {sck_oe, sdo_oe, rdy_oe}, 0);
    repeat (100) @(negedge clk);
    check(setup == 1'b1, "R3 setup held while low", setup, 1);
    req_n = 1'b1;
    repeat (6) @(negedge clk);
    check(setup == 1'b0, "R3 setup left on release", setup, 0);
    check(done_cnt == d0, "R3 nothing transmitted", done_cnt, d0);
    check(start_cnt == s0 + 1, "R3 no extra start", start_cnt, s0 + 1);

    run_txn(16'h8E71, 2, 3, 1'b0);
    check(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule